// File: doc/BRIEF.md
# Boot Mode Latch and Address Alias Decoder

This block chooses which on-chip memory answers at address zero after reset. Two boot-select pins are sampled once, a fixed number of rising clock edges after reset is released. The result is held as a boot mode. The mode picks one of three regions: main flash, a system-memory region, or SRAM. That region is mirrored into a boot window based at address zero.

Every bus address presented to the block is decoded in the same cycle. The block returns a region select and the translated physical address. An address inside the boot window becomes the alias base plus the offset. An address outside the window is decoded against the native regions and passes through unchanged, so the aliased memory is still reachable at its own base.

When the power controller signals the end of standby, the pins are sampled again and the held mode is replaced. A ready output tells the fetch logic when the mode is valid.

Top module: `boot_alias_map`

## Requirements
- R1: `bootReady` is 0 while `rstN` is low and after release stays 0 until the 4th rising clock edge after release (`SAMPLE_EDGE`). It reads 1 from that edge on.
- R2: The held mode takes the pin values present at the 4th rising edge after release. Pin values before or after that edge do not affect it.
- R3: The mode follows the pins, with `bootMode` encoded as follows.
  - `bootPin0`=0 selects flash, code 0.
  - `bootPin1`=0 with `bootPin0`=1 selects system memory, code 1.
  - Both pins at 1 select SRAM, code 2.
  - After reset, `bootMode` reads 0.
- R4: When ready, an address below `WIN_BYTES` inside the selected region's size maps to the alias base plus the address. `regionSel` gives the selected region: 1 flash, 2 system memory, 3 SRAM.
- R5: An address in a native region (flash 0x0800_0000, system memory `SYS_BASE`, SRAM 0x2000_0000, each with its size parameter) gives that region code. The physical address equals the bus address. This holds while that region is aliased too.
- R6: An address outside the window that hits no native region raises `decErr` in the same cycle, with `regionSel`=0 and `physAddr` equal to `busAddr`.
- R7: A window offset at or beyond the selected region's size raises `decErr`, with `regionSel`=0 and `physAddr` equal to `busAddr`.
- R8: While `bootReady` is 0, every window address raises `decErr` with `regionSel`=0.
- R9: When `standbyExit` is 1 at a rising edge and `bootReady` is 1, the pins at that edge replace the held mode. Before ready, `standbyExit` has no effect.
- R10: Between sampling events the held mode ignores pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bootPin0 | input | 1 | Boot-select pin 0 |
| bootPin1 | input | 1 | Boot-select pin 1 |
| standbyExit | input | 1 | One-cycle strobe: standby has ended, sample pins again |
| busAddr | input | ADDR_W | Bus address to decode |
| regionSel | output | 2 | Target region: 0 none, 1 flash, 2 system memory, 3 SRAM |
| physAddr | output | ADDR_W | Translated physical address |
| decErr | output | 1 | Address maps to no region |
| bootReady | output | 1 | Mode sampled; fetch may begin |
| bootMode | output | 2 | Held boot mode code |

## Verification
The bench sets the pins to one value in the three edges before the sampling edge and to another value right after it. A latch that captured on the wrong edge would report a mode that never held at the 4th edge. Window offsets are driven just below and just at the end of the smaller aliased regions. A decoder that checked only the window size would alias past the end of SRAM or system memory instead of raising `decErr`. The native SRAM and flash addresses are compared while their own region is aliased, which catches a decoder that lets the alias hide the native mapping. Standby-exit strobes with new pin values, plus pin changes without a strobe, show whether the mode is captured exactly on the strobe and nowhere else.

// File: rtl/boot_alias_pkg.sv
package boot_alias_pkg;

  localparam logic [1:0] MODE_FLASH = 2'd0;
  localparam logic [1:0] MODE_SYS   = 2'd1;
  localparam logic [1:0] MODE_SRAM  = 2'd2;

  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_FLASH = 2'd1,
    REG_SYS   = 2'd2,
    REG_SRAM  = 2'd3
  } region_e;

  typedef struct packed {
    logic captureStb;
    logic readyNow;
  } ctrl_strobes_t;

  function automatic logic [1:0] pinsToMode(input logic pin1, input logic pin0);
    if (!pin0)      return MODE_FLASH;
    else if (!pin1) return MODE_SYS;
    else            return MODE_SRAM;
  endfunction

endpackage

// File: rtl/boot_alias_ctrl.sv
module boot_alias_ctrl
  import boot_alias_pkg::*;
#(
  parameter int SAMPLE_EDGE = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          standbyExit,
  output ctrl_strobes_t strobes
);
  localparam int CNT_W = (SAMPLE_EDGE < 2) ? 1 : $clog2(SAMPLE_EDGE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_EDGE - 1);

  logic [CNT_W-1:0] edgeCnt;
  logic             readyQ;
  logic             firstSample;

  assign firstSample = !readyQ && (edgeCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      readyQ  <= 1'b0;
    end else if (!readyQ) begin
      if (firstSample) readyQ <= 1'b1;
      else             edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.captureStb = firstSample || (readyQ && standbyExit);
    strobes.readyNow   = readyQ;
  end

endmodule

// File: rtl/boot_alias_dp.sv
module boot_alias_dp
  import boot_alias_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] WIN_BYTES  = 'h0008_0000,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 'h0800_0000,
  parameter logic [ADDR_W-1:0] FLASH_SIZE = 'h0008_0000,
  parameter logic [ADDR_W-1:0] SYS_BASE   = 'h1FFF_F000,
  parameter logic [ADDR_W-1:0] SYS_SIZE   = 'h0000_0800,
  parameter logic [ADDR_W-1:0] SRAM_BASE  = 'h2000_0000,
  parameter logic [ADDR_W-1:0] SRAM_SIZE  = 'h0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strobes,
  input  logic              bootPin0,
  input  logic              bootPin1,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        regionSel,
  output logic [ADDR_W-1:0] physAddr,
  output logic              decErr,
  output logic [1:0]        bootMode
);
  logic [1:0] modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   modeQ <= MODE_FLASH;
    else if (strobes.captureStb) modeQ <= pinsToMode(bootPin1, bootPin0);
  end
  assign bootMode = modeQ;

  function automatic logic inRange(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] base,
                                   input logic [ADDR_W-1:0] size);
    return (a >= base) && ((a - base) < size);
  endfunction

  logic [ADDR_W-1:0] aliasBase, aliasSize;
  region_e           aliasReg;

  always_comb begin
    unique case (modeQ)
      MODE_SYS:  begin aliasBase = SYS_BASE;   aliasSize = SYS_SIZE;   aliasReg = REG_SYS;   end
      MODE_SRAM: begin aliasBase = SRAM_BASE;  aliasSize = SRAM_SIZE;  aliasReg = REG_SRAM;  end
      default:   begin aliasBase = FLASH_BASE; aliasSize = FLASH_SIZE; aliasReg = REG_FLASH; end
    endcase
  end

  region_e hitReg;
  logic    inWindow;

  always_comb begin
    inWindow = busAddr < WIN_BYTES;
    hitReg   = REG_NONE;
    physAddr = busAddr;
    if (inWindow) begin
      if (strobes.readyNow && (busAddr < aliasSize)) begin
        hitReg   = aliasReg;
        physAddr = aliasBase + busAddr;
      end
    end else if (inRange(busAddr, FLASH_BASE, FLASH_SIZE)) begin
      hitReg = REG_FLASH;
    end else if (inRange(busAddr, SYS_BASE, SYS_SIZE)) begin
      hitReg = REG_SYS;
    end else if (inRange(busAddr, SRAM_BASE, SRAM_SIZE)) begin
      hitReg = REG_SRAM;
    end
    regionSel = hitReg;
    decErr    = (hitReg == REG_NONE);
  end

endmodule

// File: rtl/boot_alias_map.sv
module boot_alias_map
  import boot_alias_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter int              SAMPLE_EDGE = 4,
  parameter logic [ADDR_W-1:0] WIN_BYTES  = 'h0008_0000,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 'h0800_0000,
  parameter logic [ADDR_W-1:0] FLASH_SIZE = 'h0008_0000,
  parameter logic [ADDR_W-1:0] SYS_BASE   = 'h1FFF_F000,
  parameter logic [ADDR_W-1:0] SYS_SIZE   = 'h0000_0800,
  parameter logic [ADDR_W-1:0] SRAM_BASE  = 'h2000_0000,
  parameter logic [ADDR_W-1:0] SRAM_SIZE  = 'h0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootPin0,
  input  logic              bootPin1,
  input  logic              standbyExit,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        regionSel,
  output logic [ADDR_W-1:0] physAddr,
  output logic              decErr,
  output logic              bootReady,
  output logic [1:0]        bootMode
);
  ctrl_strobes_t strobes;

  boot_alias_ctrl #(.SAMPLE_EDGE(SAMPLE_EDGE)) u_ctrl (
    .clk(clk), .rstN(rstN), .standbyExit(standbyExit), .strobes(strobes)
  );

  boot_alias_dp #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES),
    .FLASH_BASE(FLASH_BASE), .FLASH_SIZE(FLASH_SIZE),
    .SYS_BASE(SYS_BASE), .SYS_SIZE(SYS_SIZE),
    .SRAM_BASE(SRAM_BASE), .SRAM_SIZE(SRAM_SIZE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .bootPin0(bootPin0), .bootPin1(bootPin1), .busAddr(busAddr),
    .regionSel(regionSel), .physAddr(physAddr), .decErr(decErr), .bootMode(bootMode)
  );

  assign bootReady = strobes.readyNow;

endmodule

// File: rtl/boot_alias_map_chk.sv
module boot_alias_map_chk
  import boot_alias_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter int              SAMPLE_EDGE = 4,
  parameter logic [ADDR_W-1:0] WIN_BYTES  = 'h0008_0000,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 'h0800_0000,
  parameter logic [ADDR_W-1:0] SYS_BASE   = 'h1FFF_F000,
  parameter logic [ADDR_W-1:0] SRAM_BASE  = 'h2000_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              bootPin0,
  input logic              bootPin1,
  input logic              standbyExit,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        regionSel,
  input logic [ADDR_W-1:0] physAddr,
  input logic              decErr,
  input logic              bootReady,
  input logic [1:0]        bootMode
);
  localparam int CW = $clog2(SAMPLE_EDGE + 2);
  logic [CW-1:0] edgesSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgesSeen <= '0;
    else if (edgesSeen < CW'(SAMPLE_EDGE)) edgesSeen <= edgesSeen + 1'b1;
  end

  logic [ADDR_W-1:0] expBase;
  always_comb begin
    case (bootMode)
      MODE_SYS:  expBase = SYS_BASE;
      MODE_SRAM: expBase = SRAM_BASE;
      default:   expBase = FLASH_BASE;
    endcase
  end

  AST_READY_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    bootReady == (edgesSeen >= CW'(SAMPLE_EDGE)));                               // R1

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (bootReady && !standbyExit) |=> $stable(bootMode));                          // R10

  AST_STANDBY_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (bootReady && standbyExit) |=>
      bootMode == pinsToMode($past(bootPin1), $past(bootPin0)));                 // R9

  AST_WINDOW_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < WIN_BYTES && !decErr) |-> (physAddr == expBase + busAddr));       // R4

  AST_NOT_READY_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (!bootReady && busAddr < WIN_BYTES) |-> (decErr && regionSel == 2'd0));      // R8

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= WIN_BYTES) |-> (physAddr == busAddr));                           // R5

  AST_ERR_ZERO_REGION: assert property (@(posedge clk) disable iff (!rstN)
    decErr |-> (regionSel == 2'd0 && physAddr == busAddr));                      // R6

endmodule

bind boot_alias_map boot_alias_map_chk #(
  .ADDR_W(ADDR_W), .SAMPLE_EDGE(SAMPLE_EDGE), .WIN_BYTES(WIN_BYTES),
  .FLASH_BASE(FLASH_BASE), .SYS_BASE(SYS_BASE), .SRAM_BASE(SRAM_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .bootPin0(bootPin0), .bootPin1(bootPin1),
  .standbyExit(standbyExit), .busAddr(busAddr), .regionSel(regionSel),
  .physAddr(physAddr), .decErr(decErr), .bootReady(bootReady), .bootMode(bootMode)
);

// File: tb/boot_alias_map_bench.sv
module boot_alias_map_bench;
  localparam int          AW         = 32;
  localparam logic [31:0] WIN        = 32'h0008_0000;
  localparam logic [31:0] FL_B       = 32'h0800_0000, FL_S = 32'h0008_0000;
  localparam logic [31:0] SY_B       = 32'h1FFF_F000, SY_S = 32'h0000_0800;
  localparam logic [31:0] SR_B       = 32'h2000_0000, SR_S = 32'h0001_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bootPin0 = 1'b0, bootPin1 = 1'b0, standbyExit = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [1:0] regionSel, bootMode;
  logic [AW-1:0] physAddr;
  logic decErr, bootReady;

  int compared = 0, mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  boot_alias_map u_boot_alias_map (
    .clk(clk), .rstN(rstN), .bootPin0(bootPin0), .bootPin1(bootPin1),
    .standbyExit(standbyExit), .busAddr(busAddr), .regionSel(regionSel),
    .physAddr(physAddr), .decErr(decErr), .bootReady(bootReady), .bootMode(bootMode)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [34:0] model(input logic [31:0] a, input logic [1:0] mode,
                                        input logic rdy);
    logic [31:0] b, s; logic [1:0] r;
    b = FL_B; s = FL_S; r = 2'd1;
    if (mode == 2'd1) begin b = SY_B; s = SY_S; r = 2'd2; end
    if (mode == 2'd2) begin b = SR_B; s = SR_S; r = 2'd3; end
    if (a < WIN) begin
      if (rdy && a < s) return {1'b0, r, b + a};
      return {1'b1, 2'd0, a};
    end
    if (a >= FL_B && a - FL_B < FL_S) return {1'b0, 2'd1, a};
    if (a >= SY_B && a - SY_B < SY_S) return {1'b0, 2'd2, a};
    if (a >= SR_B && a - SR_B < SR_S) return {1'b0, 2'd3, a};
    return {1'b1, 2'd0, a};
  endfunction

  task automatic probe(input string req, input logic [31:0] a, input logic [1:0] mode,
                       input logic rdy);
    logic [34:0] e;
    busAddr = a;
    #1;
    e = model(a, mode, rdy);
    check(req, {decErr, regionSel, physAddr}, e);
  endtask

  function automatic logic [31:0] pickAddr(input logic [1:0] mode);
    logic [31:0] s;
    s = (mode == 2'd0) ? FL_S : (mode == 2'd1) ? SY_S : SR_S;
    case ($urandom % 8)
      0: return $urandom % WIN;
      1: return $urandom % s;
      2: return FL_B + ($urandom % (FL_S + 16));
      3: return SY_B + ($urandom % (SY_S + 16));
      4: return SR_B + ($urandom % (SR_S + 16));
      5: return s - 32'd1 + ($urandom % 2);
      6: return WIN - 32'd1 + ($urandom % 2);
      default: return $urandom;
    endcase
  endfunction

  task automatic randomBatch(input logic [1:0] mode, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ($urandom % 2) begin bootPin0 = $urandom; bootPin1 = $urandom; end
      probe("R4/R5/R6/R7 random", pickAddr(mode), mode, 1'b1);
      check("R10 mode held", bootMode, mode);
    end
  endtask

  task automatic bootWith(input logic p1, input logic p0, input logic [1:0] mode);
    @(negedge clk); rstN = 0; bootPin1 = ~p1; bootPin0 = ~p0;
    #1;
    check("R1 ready low in reset", bootReady, 1'b0);
    check("R3 reset mode", bootMode, 2'd0);
    @(negedge clk); rstN = 1;
    standbyExit = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    standbyExit = 0;
    check("R1 not ready after 3 edges", bootReady, 1'b0);
    check("R9 standby ignored before ready", bootMode, 2'd0);
    probe("R8 window before ready", 32'h0000_0100, 2'd0, 1'b0);
    bootPin1 = p1; bootPin0 = p0;
    @(posedge clk);
    @(negedge clk);
    bootPin1 = ~p1; bootPin0 = ~p0;
    check("R1 ready after edge 4", bootReady, 1'b1);
    check("R2/R3 sampled mode", bootMode, mode);
  endtask

  initial begin
    void'($urandom(32'h00C0_FFEE));
    repeat (3) @(negedge clk);
    bootWith(1'b1, 1'b1, 2'd2);
    probe("R4 SRAM alias at zero", 32'h0, 2'd2, 1'b1);
    probe("R7 past SRAM size", SR_S, 2'd2, 1'b1);
    probe("R5 SRAM native while aliased", SR_B + 32'h40, 2'd2, 1'b1);
    probe("R6 unmapped", 32'h4000_0000, 2'd2, 1'b1);
    randomBatch(2'd2, 300);

    @(negedge clk); bootPin1 = 0; bootPin0 = 1; standbyExit = 1;
    @(negedge clk); standbyExit = 0;
    check("R9 standby recapture sys", bootMode, 2'd1);
    probe("R7 past sys size", SY_S, 2'd1, 1'b1);
    randomBatch(2'd1, 300);

    @(negedge clk); bootPin1 = 1; bootPin0 = 0; standbyExit = 1;
    @(negedge clk); standbyExit = 0;
    check("R9 standby recapture flash", bootMode, 2'd0);
    probe("R4 flash alias top", FL_S - 1, 2'd0, 1'b1);
    randomBatch(2'd0, 300);

    bootWith(1'b0, 1'b1, 2'd1);
    randomBatch(2'd1, 200);
    bootWith(1'b0, 1'b0, 2'd0);
    probe("R5 flash native while aliased", FL_B + 32'h10, 2'd0, 1'b1);
    randomBatch(2'd0, 200);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule